// File: doc/BRIEF.md
# Three-Wire Register Port with Serial Readback

This block is the target side of a three-wire programming link. A host shifts 32-bit words in on a serial data line, most significant bit first. A pulse on the latch-enable line then stores the word in one of sixteen registers, chosen by the four lowest bits of the word. All sixteen registers appear as one flat parallel output for the surrounding logic. The serial lines are sampled by the system clock, and edges are found by comparing each line with its previous sample.

A word latched to register 7 with bit 8 set also requests a readback. The block formats one of its parallel status inputs into a 16-bit word and takes a snapshot of it at the latch. While latch-enable stays high, further serial clocks send the snapshot out on the readback pin. The output-enable is high only while the pin should be driven. The first clock drives a dummy bit, the next sixteen drive the data most significant bit first, and the eighteenth clock releases the pin. A chip-enable input freezes the whole port while it is low.

Top module: `tw_regport`

## Requirements
- R1: Each rising serial-clock edge shifts `sdata` into a 32-bit shift register, so the first bit sent ends up as bit 31 of the latched word.
- R2: A rising edge on `sle` copies the shift register into the register whose index is bits 3:0 of the word. No other register changes, and registers change only on such an edge.
- R3: While `ce` is low, serial-clock and latch edges have no effect: registers keep their values and `rb_oe` stays low.
- R4: A readback starts only when a word is latched with bits 3:0 = 7 and bit 8 = 1. If bit 8 is 0, the word is still stored, but `rb_oe` stays low through all later clocks.
- R5: After a readback starts, `rb_oe` stays low until the first serial clock. On clock 1, `rb_oe` rises with `rb_do` = 0 (dummy). Clocks 2 to 17 drive data bits 15 down to 0. Clock 18 drops `rb_oe`.
- R6: Bits 6:4 of the readback request select the source: 0 frequency error, 1 signal strength, 2 battery, 3 ADC input, 4 temperature, 5 revision, 6 filter calibration, 7 all zeros.
- R7: The signal-strength word is {5'b0, lna_gain[1:0], filt_gain[1:0], rssi_lvl[6:0]}.
- R8: The battery, ADC-input and temperature words carry their 7-bit value in bits 6:0, with zeros above. The filter-calibration word carries its 8-bit value in bits 7:0, with bits 15:8 zero. The frequency-error word is the signed 16-bit input, passed through unchanged.
- R9: The revision word is 16'h2104: product code 0x210 in bits 15:4 and revision 0x4 in bits 3:0. No register needs to be set up first.
- R10: The readback word is captured at the latch edge. Changes to the source inputs during the readback do not alter the bits sent.
- R11: Dropping `sle` before clock 18 lowers `rb_oe` in the same cycle, without waiting for a clock edge. Later serial clocks do not re-enable it.
- R12: After reset all registers read zero and `rb_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip enable; when low the port is frozen |
| sclk | input | 1 | Serial clock |
| sdata | input | 1 | Serial data, MSB first |
| sle | input | 1 | Latch enable and readback window |
| afc_val | input | 16 | Signed frequency-error value |
| rssi_lvl | input | 7 | Signal-strength level |
| filt_gain | input | 2 | Current filter gain code |
| lna_gain | input | 2 | Current LNA gain code |
| batt_val | input | 7 | Battery voltage code |
| adc_val | input | 7 | ADC input voltage code |
| temp_val | input | 7 | Temperature sensor code |
| fcal_val | input | 8 | Filter calibration code |
| regs_flat | output | 512 | Register n in bits [32n+31:32n] |
| rb_do | output | 1 | Readback data |
| rb_oe | output | 1 | Readback output enable (low = high impedance) |

## Verification
The bench builds the block with its default parameters: a 32-bit word, four address bits (sixteen registers), a 16-bit readback word, register 7 as the readback register and bit 8 as the enable bit. With these values, seeded random writes can reach every register address. Every one of the eight select codes can be requested, so each format is checked against random source values. The full 18-clock frame is observed bit by bit, with directed cases for an abort partway through, a request with bit 8 clear, a frozen port and sources that change during a read.

// File: rtl/tw_regport.sv
module tw_regport #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 4,
  parameter int RB_W = 16,
  parameter int RB_REG = 7,
  parameter int RB_BIT = 8,
  parameter int SEL_LSB = 4,
  parameter logic [RB_W-5:0] PROD_CODE = 'h210,
  parameter logic [3:0] REV_CODE = 4'h4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic sclk,
  input  logic sdata,
  input  logic sle,
  input  logic [RB_W-1:0] afc_val,
  input  logic [6:0] rssi_lvl,
  input  logic [1:0] filt_gain,
  input  logic [1:0] lna_gain,
  input  logic [6:0] batt_val,
  input  logic [6:0] adc_val,
  input  logic [6:0] temp_val,
  input  logic [7:0] fcal_val,
  output logic [(2**ADDR_W)*WORD_W-1:0] regs_flat,
  output logic rb_do,
  output logic rb_oe
);
  localparam int NREG = 2**ADDR_W;
  localparam int SEL_W = 3;
  localparam int RB_LEN = RB_W + 2;
  localparam int CNT_W = $clog2(RB_LEN + 1);

  logic sclk_q, sle_q;
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] regs [NREG];
  logic [RB_W-1:0] rb_sh, rb_word;
  logic [CNT_W-1:0] cnt;
  logic rb_act, oe_q, do_q;

  wire clk_rise = ce & sclk & ~sclk_q;
  wire le_rise  = ce & sle & ~sle_q;
  wire start    = le_rise && (sh[ADDR_W-1:0] == ADDR_W'(RB_REG)) && sh[RB_BIT];
  wire [SEL_W-1:0] sel = sh[SEL_LSB +: SEL_W];

  always_comb begin
    case (sel)
      3'd0: rb_word = afc_val;
      3'd1: rb_word = {{(RB_W-11){1'b0}}, lna_gain, filt_gain, rssi_lvl};
      3'd2: rb_word = {{(RB_W-7){1'b0}}, batt_val};
      3'd3: rb_word = {{(RB_W-7){1'b0}}, adc_val};
      3'd4: rb_word = {{(RB_W-7){1'b0}}, temp_val};
      3'd5: rb_word = {PROD_CODE, REV_CODE};
      3'd6: rb_word = {{(RB_W-8){1'b0}}, fcal_val};
      default: rb_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sle_q  <= 1'b0;
      sh     <= '0;
    end else begin
      sclk_q <= sclk;
      sle_q  <= sle;
      if (clk_rise) sh <= {sh[WORD_W-2:0], sdata};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (le_rise) begin
      regs[sh[ADDR_W-1:0]] <= sh;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*WORD_W +: WORD_W] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_act <= 1'b0;
      oe_q   <= 1'b0;
      do_q   <= 1'b0;
      cnt    <= '0;
      rb_sh  <= '0;
    end else if (start) begin
      rb_act <= 1'b1;
      oe_q   <= 1'b0;
      do_q   <= 1'b0;
      cnt    <= '0;
      rb_sh  <= rb_word;
    end else if (!ce || !sle) begin
      rb_act <= 1'b0;
      oe_q   <= 1'b0;
    end else if (rb_act && clk_rise) begin
      cnt <= cnt + 1'b1;
      if (cnt == '0) begin
        oe_q <= 1'b1;
        do_q <= 1'b0;
      end else if (cnt <= CNT_W'(RB_W)) begin
        do_q  <= rb_sh[RB_W-1];
        rb_sh <= rb_sh << 1;
      end else begin
        oe_q   <= 1'b0;
        rb_act <= 1'b0;
      end
    end
  end

  assign rb_oe = oe_q & sle & ce;
  assign rb_do = do_q & rb_oe;
endmodule

// File: rtl/tw_regport_chk.sv
module tw_regport_chk #(
  parameter int FLAT_W = 512,
  parameter int WORD_W = 32,
  parameter int RB_W = 16,
  parameter int RB_REG = 7,
  parameter int RB_BIT = 8
) (
  input logic clk,
  input logic rst_n,
  input logic ce,
  input logic sclk,
  input logic sclk_q,
  input logic sle,
  input logic sle_q,
  input logic [FLAT_W-1:0] regs_flat,
  input logic rb_do,
  input logic rb_oe
);
  logic [7:0] ecnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecnt <= '0;
    else if (!rb_oe) ecnt <= '0;
    else if (ce && sclk && !sclk_q && ecnt != 8'hff) ecnt <= ecnt + 1'b1;
  end

  p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce && sle && !sle_q) |=> $stable(regs_flat));

  p_ce_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(regs_flat));

  p_gate_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rb_oe |-> regs_flat[RB_REG*WORD_W + RB_BIT]);

  p_dummy_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_oe) |-> !rb_do);

  p_frame_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rb_oe |-> ecnt <= 8'(RB_W));
endmodule

bind tw_regport tw_regport_chk #(
  .FLAT_W((2**ADDR_W)*WORD_W), .WORD_W(WORD_W), .RB_W(RB_W),
  .RB_REG(RB_REG), .RB_BIT(RB_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sclk_q(sclk_q),
  .sle(sle), .sle_q(sle_q), .regs_flat(regs_flat), .rb_do(rb_do), .rb_oe(rb_oe)
);

// File: tb/test_tw_regport.sv
module test_tw_regport;
  logic clk = 0, rst_n = 0, ce = 1, sclk = 0, sdata = 0, sle = 0;
  logic [15:0] afc_val = 0;
  logic [6:0] rssi_lvl = 0, batt_val = 0, adc_val = 0, temp_val = 0;
  logic [1:0] filt_gain = 0, lna_gain = 0;
  logic [7:0] fcal_val = 0;
  logic [511:0] regs_flat;
  logic rb_do, rb_oe;
  logic [31:0] exp_regs [16];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tw_regport i_tw_regport (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    sclk = 1; tick(2); sclk = 0; tick(2);
  endtask

  task automatic shift_word(input logic [31:0] w);
    sle = 0; tick(2);
    for (int i = 31; i >= 0; i--) begin sdata = w[i]; pulse(); end
    sdata = 0;
  endtask

  task automatic write_word(input logic [31:0] w);
    shift_word(w);
    sle = 1; tick(2); sle = 0; tick(2);
    if (ce) exp_regs[w[3:0]] = w;
  endtask

  task automatic check_regs(input string tag);
    int bad = 0;
    int first = -1;
    for (int k = 0; k < 16; k++)
      if (regs_flat[k*32 +: 32] !== exp_regs[k]) begin bad++; if (first < 0) first = k; end
    if (first < 0) first = 0;
    chk(bad == 0, tag, regs_flat[first*32 +: 32], exp_regs[first]);
  endtask

  function automatic logic [15:0] fmt(input logic [2:0] s);
    case (s)
      3'd0: return afc_val;
      3'd1: return {5'b0, lna_gain, filt_gain, rssi_lvl};
      3'd2: return {9'b0, batt_val};
      3'd3: return {9'b0, adc_val};
      3'd4: return {9'b0, temp_val};
      3'd5: return 16'h2104;
      3'd6: return {8'b0, fcal_val};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic randomize_sources();
    afc_val = 16'($urandom); rssi_lvl = 7'($urandom); filt_gain = 2'($urandom);
    lna_gain = 2'($urandom); batt_val = 7'($urandom); adc_val = 7'($urandom);
    temp_val = 7'($urandom); fcal_val = 8'($urandom);
  endtask

  task automatic do_read(input logic [2:0] s, input bit mutate, input string tag);
    logic [31:0] w;
    logic [15:0] exp, got;
    got = 0;
    w = $urandom;
    w[3:0] = 4'h7; w[8] = 1'b1; w[6:4] = s;
    shift_word(w);
    sle = 1; tick(2);
    exp_regs[7] = w;
    exp = fmt(s);
    chk(rb_oe === 1'b0, "R5 no drive before first clock", rb_oe, 0);
    if (mutate) randomize_sources();
    for (int k = 1; k <= 18; k++) begin
      sclk = 1; tick(2);
      if (k == 1) chk(rb_oe === 1'b1 && rb_do === 1'b0, "R5 dummy bit", {rb_oe, rb_do}, 2'b10);
      else if (k <= 17) begin
        if (rb_oe !== 1'b1) chk(0, "R5 oe during data", rb_oe, 1);
        got[17-k] = rb_do;
      end else chk(rb_oe === 1'b0, "R5 release on clock 18", rb_oe, 0);
      sclk = 0; tick(2);
    end
    chk(got === exp, tag, got, exp);
    sle = 0; tick(2);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd4711));
    for (int k = 0; k < 16; k++) exp_regs[k] = 0;
    tick(4); rst_n = 1; tick(2);
    // R12 reset state
    check_regs("R12 registers zero after reset");
    chk(rb_oe === 1'b0, "R12 output released after reset", rb_oe, 0);

    // R9 revision readable with no setup
    do_read(3'd5, 0, "R9 revision word");

    // R1 R2 directed and random writes
    write_word(32'h8000_0003);
    chk(regs_flat[3*32 +: 32] === 32'h8000_0003, "R1 first bit lands in bit 31", regs_flat[3*32 +: 32], 32'h8000_0003);
    for (int n = 0; n < 60; n++) begin
      w = $urandom;
      if (w[3:0] == 4'h7) w[8] = 1'b0;
      write_word(w);
      check_regs("R2 register bank after write");
    end

    // R4 request with bit 8 clear
    write_word(32'h0000_0057);
    begin
      int seen = 0;
      sle = 1; tick(2);
      for (int k = 0; k < 18; k++) begin
        sclk = 1; tick(2); if (rb_oe !== 1'b0) seen++; sclk = 0; tick(2);
      end
      sle = 0; tick(2);
      chk(seen == 0, "R4 no readback without bit 8", seen, 0);
    end
    check_regs("R4 word stored without readback");

    // R6 R7 R8 every select code with random sources
    for (int r = 0; r < 3; r++)
      for (int s = 0; s < 8; s++) begin
        randomize_sources();
        do_read(3'(s), 0, s == 1 ? "R7 signal strength word" :
                          (s == 0 || s > 1) ? "R6 R8 selected source word" : "R6");
      end
    afc_val = 16'h8001;
    do_read(3'd0, 0, "R8 negative frequency error");
    fcal_val = 8'hff;
    do_read(3'd6, 0, "R8 filter calibration upper zero");

    // R10 sources change during read
    for (int r = 0; r < 4; r++) begin
      randomize_sources();
      do_read(3'd1, 1, "R10 snapshot at latch");
    end

    // R11 abort
    begin
      int seen = 0;
      w = 32'h0000_0117;
      shift_word(w); exp_regs[7] = w;
      sle = 1; tick(2);
      for (int k = 0; k < 5; k++) pulse();
      chk(rb_oe === 1'b1, "R11 readback running", rb_oe, 1);
      @(negedge clk); sle = 0; #1;
      chk(rb_oe === 1'b0, "R11 immediate release", rb_oe, 0);
      tick(2);
      for (int k = 0; k < 16; k++) begin
        sclk = 1; tick(2); if (rb_oe !== 1'b0) seen++; sclk = 0; tick(2);
      end
      chk(seen == 0, "R11 stays released after abort", seen, 0);
    end

    // R3 frozen while chip enable low
    ce = 0;
    write_word(32'hdead_bee5);
    check_regs("R3 writes ignored when disabled");
    shift_word(32'h0000_0117);
    sle = 1; tick(2);
    begin
      int seen = 0;
      for (int k = 0; k < 18; k++) begin
        sclk = 1; tick(2); if (rb_oe !== 1'b0) seen++; sclk = 0; tick(2);
      end
      chk(seen == 0, "R3 no readback when disabled", seen, 0);
    end
    sle = 0; tick(2);
    check_regs("R3 registers unchanged when disabled");
    ce = 1; tick(2);
    write_word(32'h1234_5672);
    check_regs("R2 writes resume after enable");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule